// File: doc/BRIEF.md
# Burst Column Sequencer

This block turns one column command into the list of column addresses for a double-data-rate burst, one address per data beat. A command supplies a starting column, a length code (2, 4 or 8 beats) and an order bit. The sequencer then walks through the aligned block that holds the starting column. In linear order it counts upward and wraps inside the block. In interleaved order it XORs the beat number into the low column bits. The column bits above the block stay fixed.

A burst can end early. A terminate pulse marks the beat shown in that cycle as the final one. A new command that arrives during a burst abandons the old one, and the next cycle shows the first beat of the new burst. If that new command lands on the final beat of the old burst, the two bursts run back to back with no gap. The block computes addresses only. It does not touch the memory array or the data strobes.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until a command is accepted, `beat_valid` and `beat_last` are 0.
- R2: A command sampled with `cmd_start`=1 gives, in the next cycle, `beat_valid`=1, `beat_idx`=0 and `beat_col` equal to the sampled `cmd_col`.
- R3: `cmd_len_code` selects the burst length. Code 1 gives 2 beats, code 2 gives 4 beats and code 3 gives 8 beats. Code 0 is treated as 2 beats. `beat_idx` counts 0,1,2,… in consecutive cycles.
- R4: With `cmd_order`=0 (linear), the low log2(BL) bits of beat k equal (start + k) mod BL.
- R5: With `cmd_order`=1 (interleaved), the low log2(BL) bits of beat k equal start XOR k.
- R6: The column bits above the low log2(BL) bits equal those of the start column on every beat.
- R7: `beat_last` is 1 on the final beat of an uninterrupted burst. Without a new command, `beat_valid` is 0 in the following cycle.
- R8: `cmd_term`=1 during a valid beat makes `beat_last`=1 in that same cycle, and the burst ends after that beat. `cmd_term` has no effect while no beat is valid.
- R9: A `cmd_start` during a burst abandons it. The next cycle shows beat 0 of the new command.
- R10: A `cmd_start` on the final beat of a burst chains the bursts: `beat_valid` stays 1 with no idle cycle between them.
- R11: When `cmd_start` and `cmd_term` arrive in the same cycle, the current beat shows `beat_last`=1 and the next cycle still begins the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Accept a new column command this cycle |
| cmd_col | input | COL_W (10) | Starting column |
| cmd_len_code | input | CODE_W (2) | Burst length code: 0 or 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats |
| cmd_order | input | 1 | 0 selects linear order, 1 selects interleaved order |
| cmd_term | input | 1 | End the current burst after this beat |
| beat_valid | output | 1 | A beat address is presented |
| beat_col | output | COL_W (10) | Column address of the current beat |
| beat_idx | output | MAX_LOG (3) | Position of the current beat within the burst |
| beat_last | output | 1 | The current beat is the final one |

## Verification
Two of the block's functions can fall in the same cycle: a new command can coincide with a terminate pulse, and it can also coincide with the natural final beat of the running burst. The bench raises `cmd_start` together with `cmd_term` partway through a burst of 8. It also raises `cmd_start` exactly on the fourth beat of a burst of 4. A behavioural model predicts every cycle, so the flagged last beat, the absence or presence of an idle gap, and the first address of the following burst are all judged against the requirements on each clock.

// File: rtl/burst_seq_pkg.sv
// Shared types and helpers for the burst column sequencer.
// Assumes burst lengths are powers of two, no larger than 2**MAX_LOG.
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } beat_order_e;

    // Map a length code to log2(burst length). Code 0 counts as code 1,
    // and codes above max_log are clamped to max_log.
    function automatic int code_to_log(input int code, input int max_log);
        if (code < 1)
            return 1;
        else if (code > max_log)
            return max_log;
        else
            return code;
    endfunction

endpackage

// File: rtl/bseq_len_decode.sv
// Length decoder: turns a burst length code into a mask of the low column
// bits that the burst walks through. Assumes MAX_LOG >= 1.
module bseq_len_decode #(
    parameter int MAX_LOG = 3,
    parameter int CODE_W  = $clog2(MAX_LOG + 1)
) (
    input  logic [CODE_W-1:0]  len_code,
    output logic [MAX_LOG-1:0] low_mask
);
    import burst_seq_pkg::*;

    // Set one mask bit for each address bit that the burst walks through.
    always_comb begin
        int eff_log;
        eff_log = code_to_log(int'(len_code), MAX_LOG);
        for (int i = 0; i < MAX_LOG; i++)
            low_mask[i] = (i < eff_log);
    end
endmodule

// File: rtl/bseq_col_map.sv
// Column mapper: builds the column address of one beat from the burst base
// column, the beat index and the low-bit mask. Bits outside the mask come
// from the base unchanged. Assumes COL_W > MAX_LOG and that idx never has
// bits set outside the mask.
module bseq_col_map #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input  logic [COL_W-1:0]   base_col,
    input  logic [MAX_LOG-1:0] idx,
    input  logic [MAX_LOG-1:0] low_mask,
    input  logic               order_xor,
    output logic [COL_W-1:0]   col
);
    logic [MAX_LOG-1:0] lin_sum;

    // Linear order: add the beat index to the low bits; the carry falls off
    // the top, so the count wraps inside the block.
    always_comb lin_sum = base_col[MAX_LOG-1:0] + idx;

    // One selector per low bit: keep the base bit outside the mask,
    // otherwise take the linear or the interleaved value.
    for (genvar b = 0; b < MAX_LOG; b++) begin : g_low
        always_comb begin
            if (!low_mask[b])
                col[b] = base_col[b];
            else if (order_xor)
                col[b] = base_col[b] ^ idx[b];
            else
                col[b] = lin_sum[b];
        end
    end

    // The upper column bits never change within a burst.
    always_comb col[COL_W-1:MAX_LOG] = base_col[COL_W-1:MAX_LOG];
endmodule

// File: rtl/bseq_beat_ctrl.sv
// Beat controller: holds the burst that is in flight and advances the beat
// index each cycle. A start command has priority over a terminate pulse and
// over the natural end of the burst. Assumes the mask is contiguous from bit 0.
module bseq_beat_ctrl #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               term,
    input  logic [COL_W-1:0]   start_col,
    input  logic [MAX_LOG-1:0] start_mask,
    input  logic               start_xor,
    output logic               act_q,
    output logic [MAX_LOG-1:0] idx_q,
    output logic [MAX_LOG-1:0] mask_q,
    output logic               xor_q,
    output logic [COL_W-1:0]   base_q,
    output logic               last
);
    logic at_end;

    // The beat shown now is final if it is the natural end or a terminate is applied.
    always_comb at_end = (idx_q == mask_q);
    always_comb last   = act_q && (at_end || term);

    // Burst state: load on start, otherwise step forward or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            idx_q  <= '0;
            mask_q <= '0;
            xor_q  <= 1'b0;
            base_q <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            idx_q  <= '0;
            mask_q <= start_mask;
            xor_q  <= start_xor;
            base_q <= start_col;
        end else if (act_q) begin
            if (last)
                act_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    // R2
    load_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (act_q && idx_q == '0));

    // R7
    natural_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && at_end && !start) |=> !act_q);

    // R8
    term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && term && !start) |=> !act_q);

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !at_end && !term && !start) |=> (act_q && idx_q == $past(idx_q) + 1'b1));

    // R3
    idx_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> ((idx_q & ~mask_q) == '0));
endmodule

// File: rtl/burst_col_seq.sv
// Burst column sequencer top: decodes the command's length, tracks the
// burst and maps each beat to a column address. All outputs follow the
// registered burst state, except beat_last, which also reflects cmd_term
// in the same cycle.
module burst_col_seq #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3,
    parameter int CODE_W  = $clog2(MAX_LOG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [COL_W-1:0]   cmd_col,
    input  logic [CODE_W-1:0]  cmd_len_code,
    input  logic               cmd_order,
    input  logic               cmd_term,
    output logic               beat_valid,
    output logic [COL_W-1:0]   beat_col,
    output logic [MAX_LOG-1:0] beat_idx,
    output logic               beat_last
);
    import burst_seq_pkg::*;

    logic [MAX_LOG-1:0] new_mask;
    logic [MAX_LOG-1:0] cur_mask;
    logic [COL_W-1:0]   cur_base;
    logic               cur_xor;
    logic               act;

    bseq_len_decode #(.MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) u_len (
        .len_code (cmd_len_code),
        .low_mask (new_mask)
    );

    bseq_beat_ctrl #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_start),
        .term       (cmd_term),
        .start_col  (cmd_col),
        .start_mask (new_mask),
        .start_xor  (cmd_order == ORD_XOR),
        .act_q      (act),
        .idx_q      (beat_idx),
        .mask_q     (cur_mask),
        .xor_q      (cur_xor),
        .base_q     (cur_base),
        .last       (beat_last)
    );

    bseq_col_map #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_map (
        .base_col  (cur_base),
        .idx       (beat_idx),
        .low_mask  (cur_mask),
        .order_xor (cur_xor),
        .col       (beat_col)
    );

    // Expose the in-flight flag as the beat-valid output.
    always_comb beat_valid = act;

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !cmd_start)
            |=> (beat_col[COL_W-1:MAX_LOG] == $past(beat_col[COL_W-1:MAX_LOG])));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> !beat_last);
endmodule

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
    localparam int COL_W = 10;
    localparam int MAX_LOG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [1:0] cmd_len_code = '0;
    logic cmd_order = 1'b0;
    logic cmd_term = 1'b0;
    logic beat_valid;
    logic [COL_W-1:0] beat_col;
    logic [MAX_LOG-1:0] beat_idx;
    logic beat_last;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural model state.
    int m_act = 0, m_idx = 0, m_len = 2, m_ord = 0, m_base = 0;

    always #2.5 clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
        .cmd_len_code(cmd_len_code), .cmd_order(cmd_order), .cmd_term(cmd_term),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_idx(beat_idx),
        .beat_last(beat_last)
    );

    function automatic int len_of(input int code);
        if (code <= 1) return 2;
        if (code == 2) return 4;
        return 8;
    endfunction

    function automatic int exp_col(input int base, input int k, input int len, input int ord);
        int low;
        if (ord != 0) low = (base % len) ^ k;
        else          low = ((base % len) + k) % len;
        return (base - (base % len)) + low;
    endfunction

    // Drive one cycle of stimulus, compare against the model, then advance the model.
    task automatic step(input bit s, input int col, input int code, input bit o,
                        input bit t, input string tag);
        int ev, el, ec, ek;
        @(negedge clk);
        cmd_start = s; cmd_col = COL_W'(col); cmd_len_code = 2'(code);
        cmd_order = o; cmd_term = t;
        #0.5;
        ev = m_act;
        el = (m_act != 0 && (t || m_idx == m_len - 1)) ? 1 : 0;
        ec = exp_col(m_base, m_idx, m_len, m_ord);
        ek = m_idx;
        checks++;
        if (beat_valid !== 1'(ev) || beat_last !== 1'(el) ||
            (ev != 0 && (int'(beat_col) != ec || int'(beat_idx) != ek))) begin
            failures++;
            $display("FAIL %s: valid/last/col/idx actual %0d/%0d/%0h/%0d expected %0d/%0d/%0h/%0d",
                     tag, beat_valid, beat_last, beat_col, beat_idx, ev, el, ec, ek);
        end
        if (s) begin
            m_act = 1; m_idx = 0; m_len = len_of(code); m_ord = o; m_base = col;
        end else if (m_act != 0) begin
            if (el != 0) m_act = 0;
            else m_idx++;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: outputs quiet while held in reset
        @(negedge clk);
        checks++;
        if (beat_valid !== 1'b0 || beat_last !== 1'b0) begin
            failures++;
            $display("FAIL R1: valid/last actual %0d/%0d expected 0/0", beat_valid, beat_last);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // R2 R3 R4 R5 R6 R7: every length code, order and start offset
        for (int code = 0; code < 4; code++)
            for (int o = 0; o < 2; o++)
                for (int off = 0; off < 8; off++) begin
                    int col;
                    col = (((code * 2 + o) * 8 + off) << 3) | off;
                    step(1, col, code, o[0], 0, "R2");
                    for (int k = 0; k < 9; k++)
                        step(0, 0, 0, 0, 0, (o != 0) ? "R3 R5 R6 R7" : "R3 R4 R6 R7");
                end

        // R8: terminate a burst of 8 after the fourth beat
        step(1, 10'h2A5, 3, 0, 0, "R8");
        idle(3, "R8");
        step(0, 0, 0, 0, 1, "R8");
        idle(2, "R8");
        // R8: terminate while idle has no effect
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 1, "R8");
        idle(1, "R8");

        // R9: interrupt a burst of 8 with an interleaved burst of 4
        step(1, 10'h133, 3, 0, 0, "R9");
        idle(2, "R9");
        step(1, 10'h0F6, 2, 1, 0, "R9");
        idle(6, "R9");

        // R10: chain two bursts of 4 with no gap
        step(1, 10'h041, 2, 0, 0, "R10");
        idle(3, "R10");
        step(1, 10'h07E, 2, 1, 0, "R10");
        idle(6, "R10");

        // R11: start and terminate together mid-burst
        step(1, 10'h1C3, 3, 1, 0, "R11");
        idle(2, "R11");
        step(1, 10'h35A, 1, 0, 1, "R11");
        idle(4, "R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule